// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Resolver

This block is the decision core of an interrupt controller with eight request inputs. Request lines are captured into a pending register, either on a rising edge or by following the input level. A software-written mask hides selected inputs. A fixed-priority picker chooses the most urgent unmasked pending input and compares it against the interrupts already being serviced. The interrupt line to the processor is raised only when that input outranks everything currently in service.

When the processor acknowledges, the block presents an 8-bit vector in the same cycle. The vector's upper five bits come from a programmed base, and its lower three bits are the number of the winning input. On the acknowledge, the winning input moves from pending to in service. Service ends in one of two ways. A non-specific end-of-interrupt pulse retires the most urgent in-service input. In automatic mode, the in-service bit is never kept at all.

Configuration values (trigger mode, automatic end mode, vector base), mask writes and end-of-interrupt pulses arrive from an external command decoder. This block only acts on them.

Top module: `irq_prio_core`

## Requirements
- R1: While `rst` is high on a clock edge, the block empties the pending and in-service registers and sets all eight mask bits. After reset, `irq_out` is low and stays low until a request arrives and its mask bit is cleared.
- R2: A mask write (`mask_we` high at a clock edge) loads `mask_wdata`, where bit i hides input i. A masked pending request never raises `irq_out`. A masked request stays pending, and raises `irq_out` once its mask bit is cleared.
- R3: Priority is fixed: input 0 is the most urgent and input 7 the least. The acknowledged input is always the lowest-numbered unmasked pending one.
- R4: `vec_out` is bits 7..3 of `cfg_base` followed by the 3-bit winning input number. Bits 2..0 of `cfg_base` are ignored.
- R5: When `inta` is high while `irq_out` is high, `vec_valid` is high in that same cycle. At the next edge, the winner's pending bit is cleared.
- R6: `irq_out` is high only when some unmasked input is pending and no in-service input has an equal or lower number than it.
- R7: An `eoi` pulse clears the lowest-numbered set in-service bit. Requests that were blocked by that bit are then issued again.
- R8: With `cfg_auto_eoi` high, an acknowledge leaves no in-service bit. Further requests of equal or lower urgency are issued without any `eoi`.
- R9: With `cfg_level` high, the pending bit follows the input level, delayed by one clock. If the input drops before acknowledge, `irq_out` falls one clock later.
- R10: With `cfg_level` low, a 0-to-1 transition of the input, seen between two consecutive clock edges, sets the pending bit. An input held high is not latched again after its acknowledge; it must go low and then rise again.
- R11: `inta` while `irq_out` is low gives `vec_valid` low and changes neither the pending nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request lines, bit i = input i |
| cfg_level | input | 1 | 1 = level-sensitive requests, 0 = rising-edge requests |
| cfg_auto_eoi | input | 1 | 1 = no in-service bit is kept on acknowledge |
| cfg_base | input | 8 | Vector base; only bits 7..3 are used |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 8 | New mask value, bit i hides input i |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| inta | input | 1 | Acknowledge strobe from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector on `vec_out` is valid for this acknowledge |
| vec_out | output | 8 | Interrupt vector |

## Verification
The hardest state to reach is a nest of two in-service interrupts with a blocked, lower-urgency request waiting behind them. In that state, the retire order of `eoi` is visible only through when `irq_out` comes back. The stimulus builds this state in order: it acknowledges input 3, queues input 5 (blocked), then lets input 1 preempt and acknowledges it. The first `eoi` must leave `irq_out` low, and the second must release input 5. The level-mode case uses the same approach: a held input that has just been acknowledged must be blocked by its own in-service bit until `eoi` arrives.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int IRQ_N = 8;
    localparam int VEC_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef enum logic {
        END_BY_CMD  = 1'b0,
        END_BY_AUTO = 1'b1
    } end_mode_e;

    typedef struct packed {
        logic       hit;
        logic [2:0] idx;
    } pick_t;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = irq_prio_pkg::IRQ_N,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_prio_pkg::*;
#(
    parameter int N = IRQ_N
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [N-1:0] req_in,
    input  trig_mode_e trig,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] irr_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;
    logic [N-1:0] irr_d;

    assign rise = req_in & ~prev_q;

    always_comb begin
        if (trig == TRIG_LEVEL) irr_d = req_in & ~clr_mask;
        else                    irr_d = (irr_q & ~clr_mask) | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            prev_q <= '0;
        end else begin
            irr_q  <= irr_d;
            prev_q <= req_in;
        end
    end

    // R10: in edge mode a newly pending bit must come from an input that was low before
    a_r10_edge_needs_low: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_EDGE) |=> ((irr_q & ~$past(irr_q) & $past(prev_q)) == '0));
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track #(
    parameter int N  = irq_prio_pkg::IRQ_N,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  set_mask,
    input  logic          eoi,
    output logic [N-1:0]  isr_q,
    output logic          top_hit,
    output logic [IW-1:0] top_idx
);
    logic [N-1:0] eoi_clr;

    irq_prio_pick #(.N(N), .IW(IW)) u_top (
        .vec (isr_q),
        .hit (top_hit),
        .idx (top_idx)
    );

    assign eoi_clr = (eoi && top_hit) ? (N'(1) << top_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~eoi_clr) | set_mask;
    end

    // R7: an end-of-interrupt with nothing newly set removes exactly one in-service bit
    a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr_q != '0 && set_mask == '0) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int VW = VEC_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_in,
    input  logic          cfg_level,
    input  logic          cfg_auto_eoi,
    input  logic [VW-1:0] cfg_base,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          eoi,
    input  logic          inta,
    output logic          irq_out,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out
);
    trig_mode_e    trig;
    end_mode_e     end_mode;
    logic [N-1:0]  imr_q;
    logic [N-1:0]  irr_q;
    logic [N-1:0]  isr_q;
    logic [N-1:0]  pend;
    logic [N-1:0]  ack_mask;
    logic [N-1:0]  isr_set;
    logic          win_hit;
    logic [IW-1:0] win_idx;
    logic          top_hit;
    logic [IW-1:0] top_idx;
    logic          fire;

    assign trig     = trig_mode_e'(cfg_level);
    assign end_mode = end_mode_e'(cfg_auto_eoi);

    always_ff @(posedge clk) begin
        if (rst)          imr_q <= '1;
        else if (mask_we) imr_q <= mask_wdata;
    end

    irq_req_latch #(.N(N)) u_req (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .trig     (trig),
        .clr_mask (ack_mask),
        .irr_q    (irr_q)
    );

    assign pend = irr_q & ~imr_q;

    irq_prio_pick #(.N(N), .IW(IW)) u_win (
        .vec (pend),
        .hit (win_hit),
        .idx (win_idx)
    );

    irq_isr_track #(.N(N), .IW(IW)) u_isr (
        .clk      (clk),
        .rst      (rst),
        .set_mask (isr_set),
        .eoi      (eoi),
        .isr_q    (isr_q),
        .top_hit  (top_hit),
        .top_idx  (top_idx)
    );

    assign irq_out   = win_hit && (!top_hit || (win_idx < top_idx));
    assign fire      = inta && irq_out;
    assign ack_mask  = fire ? (N'(1) << win_idx) : '0;
    assign isr_set   = (end_mode == END_BY_AUTO) ? '0 : ack_mask;
    assign vec_valid = fire;
    assign vec_out   = {cfg_base[VW-1:IW], win_idx};

    // R1: the cycle after a reset edge shows no interrupt
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !irq_out);

    // R2: the input driving the interrupt is never a masked one
    a_r2_winner_unmasked: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (imr_q[win_idx] == 1'b0));

    // R6: no in-service bit at or above the winner's urgency while the interrupt is raised
    a_r6_nest_block: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((isr_q & ((N'(2) << win_idx) - N'(1))) == '0));

    // R8: automatic mode leaves the acknowledged input out of service
    a_r8_auto_no_isr: assert property (@(posedge clk) disable iff (rst)
        (fire && cfg_auto_eoi) |=> !isr_q[$past(win_idx)]);

    // R5: a command-mode acknowledge puts something in service
    a_r5_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
        (fire && !cfg_auto_eoi) |=> (isr_q != '0));
endmodule

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] req_in;
    logic       cfg_level;
    logic       cfg_auto_eoi;
    logic [7:0] cfg_base;
    logic       mask_we;
    logic [7:0] mask_wdata;
    logic       eoi;
    logic       inta;
    logic       irq_out;
    logic       vec_valid;
    logic [7:0] vec_out;

    int    n_total = 0;
    int    n_bad   = 0;
    bit    done    = 0;
    string phase   = "R1";

    always #4 clk = ~clk;

    irq_prio_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .req_in       (req_in),
        .cfg_level    (cfg_level),
        .cfg_auto_eoi (cfg_auto_eoi),
        .cfg_base     (cfg_base),
        .mask_we      (mask_we),
        .mask_wdata   (mask_wdata),
        .eoi          (eoi),
        .inta         (inta),
        .irq_out      (irq_out),
        .vec_valid    (vec_valid),
        .vec_out      (vec_out)
    );

    // behavioural reference state
    bit m_irr[8];
    bit m_isr[8];
    bit m_imr[8];
    bit m_prev[8];

    function automatic int m_winner();
        for (int i = 0; i < 8; i++) if (m_irr[i] && !m_imr[i]) return i;
        return -1;
    endfunction

    function automatic bit m_irq();
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) return 0;
            if (m_irr[i] && !m_imr[i]) return 1;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_irr[i] = 0; m_isr[i] = 0; m_imr[i] = 1; m_prev[i] = 0;
            end
        end else begin
            bit fire_m;
            int w;
            fire_m = inta && m_irq();
            w = m_winner();
            if (eoi) begin
                for (int i = 0; i < 8; i++) if (m_isr[i]) begin m_isr[i] = 0; break; end
            end
            if (fire_m && !cfg_auto_eoi) m_isr[w] = 1;
            for (int i = 0; i < 8; i++) begin
                bit clr_b;
                clr_b = fire_m && (i == w);
                if (cfg_level) m_irr[i] = req_in[i] && !clr_b;
                else           m_irr[i] = (m_irr[i] && !clr_b) || (req_in[i] && !m_prev[i]);
                m_prev[i] = req_in[i];
                if (mask_we) m_imr[i] = mask_wdata[i];
            end
        end
    end

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // cycle compare against the reference, away from the clock edge
    always @(negedge clk) begin
        #3;
        if (!rst && !done) begin
            bit ei;
            int w;
            ei = m_irq();
            w  = m_winner();
            chk({phase, " irq"}, {7'd0, irq_out}, {7'd0, ei});
            chk({phase, " valid"}, {7'd0, vec_valid}, {7'd0, inta && ei});
            if (inta && ei) chk({phase, " vec"}, vec_out, {cfg_base[7:3], 3'(w)});
        end
    end

    task automatic adv();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_req(logic [7:0] m);
        req_in = m;
        adv();
        req_in = '0;
    endtask

    task automatic ack(string tag, logic [7:0] exp_vec);
        inta = 1'b1;
        #2;
        chk(tag, {7'd0, vec_valid}, 8'd1);
        chk(tag, vec_out, exp_vec);
        adv();
        inta = 1'b0;
    endtask

    task automatic send_eoi();
        eoi = 1'b1;
        adv();
        eoi = 1'b0;
    endtask

    task automatic write_mask(logic [7:0] m);
        mask_we = 1'b1;
        mask_wdata = m;
        adv();
        mask_we = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_in = '0; cfg_level = 1'b0; cfg_auto_eoi = 1'b0;
        cfg_base = 8'h90; mask_we = 1'b0; mask_wdata = '0; eoi = 1'b0; inta = 1'b0;
        adv(); adv(); adv();
        rst = 1'b0;
        #2;
        chk("R1 irq after reset", {7'd0, irq_out}, 8'd0);
        adv();

        // R2: masked request stays pending but silent
        phase = "R2";
        pulse_req(8'h08);
        #2; chk("R2 masked silent", {7'd0, irq_out}, 8'd0);
        adv();
        write_mask(8'hF7);
        #2; chk("R2 unmask raises", {7'd0, irq_out}, 8'd1);
        adv();
        phase = "R5";
        ack("R4 R5 vector of input 3", 8'h93);
        #2; chk("R5 pending cleared", {7'd0, irq_out}, 8'd0);
        adv();
        write_mask(8'h00);

        // R6 / R7: nesting and retire order
        phase = "R6";
        pulse_req(8'h20);
        #2; chk("R6 input5 blocked by 3", {7'd0, irq_out}, 8'd0);
        adv();
        pulse_req(8'h02);
        #2; chk("R6 input1 preempts", {7'd0, irq_out}, 8'd1);
        adv();
        ack("R6 vector input 1", 8'h91);
        phase = "R7";
        send_eoi();
        #2; chk("R7 first eoi keeps 3", {7'd0, irq_out}, 8'd0);
        adv();
        send_eoi();
        #2; chk("R7 second eoi frees 5", {7'd0, irq_out}, 8'd1);
        adv();
        ack("R7 vector input 5", 8'h95);
        send_eoi();

        // R3 / R4: fixed order and base low bits ignored
        phase = "R3";
        cfg_base = 8'h4D;
        pulse_req(8'h54);
        ack("R3 first input 2", 8'h4A);
        send_eoi();
        ack("R3 then input 4", 8'h4C);
        send_eoi();
        ack("R3 last input 6", 8'h4E);
        send_eoi();

        // R11: acknowledge with nothing pending
        phase = "R11";
        inta = 1'b1;
        #2; chk("R11 no vector", {7'd0, vec_valid}, 8'd0);
        adv();
        inta = 1'b0;
        pulse_req(8'h08);
        ack("R11 state intact", 8'h4B);
        send_eoi();

        // R8: automatic end of interrupt
        phase = "R8";
        cfg_auto_eoi = 1'b1;
        pulse_req(8'h10);
        ack("R8 input 4", 8'h4C);
        pulse_req(8'h10);
        #2; chk("R8 same level reissued", {7'd0, irq_out}, 8'd1);
        adv();
        ack("R8 input 4 again", 8'h4C);
        pulse_req(8'h40);
        ack("R8 lower without eoi", 8'h4E);
        cfg_auto_eoi = 1'b0;
        adv();

        // R9: level mode
        phase = "R9";
        cfg_level = 1'b1;
        req_in = 8'h04;
        adv();
        #2; chk("R9 level raises", {7'd0, irq_out}, 8'd1);
        adv();
        req_in = 8'h00;
        adv();
        #2; chk("R9 level drop", {7'd0, irq_out}, 8'd0);
        adv();
        req_in = 8'h04;
        adv();
        ack("R9 level vector", 8'h4A);
        #2; chk("R6 equal blocked", {7'd0, irq_out}, 8'd0);
        adv();
        send_eoi();
        #2; chk("R9 reissued after eoi", {7'd0, irq_out}, 8'd1);
        adv();
        req_in = 8'h00;
        adv();
        cfg_level = 1'b0;
        adv();

        // R10: edge mode needs a new rise
        phase = "R10";
        req_in = 8'h80;
        adv();
        ack("R10 input 7", 8'h4F);
        send_eoi();
        adv(); adv();
        #2; chk("R10 held high not relatched", {7'd0, irq_out}, 8'd0);
        adv();
        req_in = 8'h00;
        adv();
        req_in = 8'h80;
        adv();
        #2; chk("R10 new rise latched", {7'd0, irq_out}, 8'd1);
        adv();
        ack("R10 input 7 again", 8'h4F);
        send_eoi();
        req_in = 8'h00;
        adv(); adv();

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule